// File: doc/BRIEF.md
# Maskable Exception Interrupt Controller

This block gathers up to sixteen single-cycle exception events into a sticky status word and drives an active-low interrupt pin toward a host. Each event bit, once seen, stays set until the host reads the status word. A read strobe clears the word on the next clock edge. An event that arrives in the same cycle as the read is kept, so no event is lost.

A writable 16-bit mask decides which status bits may pull the interrupt pin low. A mask bit of 1 suppresses its event. A mask bit of 0 lets it through. The mask acts only on the pin: masked events are still recorded in the status word. Several bit positions have fixed meanings:
- bit 0: no-copy flag.
- bit 13: widescreen-signalling data captured.
- bit 14: closed-caption data captured.
- bit 15: memory resynchronisation after an input discontinuity.

The no-copy flag is only recorded while widescreen-signalling capture is enabled.

Top module: `exc_irq_ctrl`

## Requirements
- R1: After reset, the status word is zero, every mask bit is 1 (all events masked), and `irq_no` is high.
- R2: An event pulse on `evt_i[k]` sets `stat_o[k]` at the next clock edge. The bit stays set until a read, whatever the mask value.
- R3: A cycle with `stat_rd_i` high clears every status bit at the next edge, except the bits named in R4.
- R4: An event present in the same cycle as `stat_rd_i` leaves its status bit set after that edge.
- R5: `irq_no` is low exactly when some status bit is set while its mask bit is 0. Otherwise it is high.
- R6: A cycle with `mask_we_i` high loads `mask_wdata_i` into the mask at the next edge. `irq_no` follows the new mask from that edge on.
- R7: An event on bit 0 (no-copy) is recorded only while `wss_cap_en_i` is high. With `wss_cap_en_i` low, bit 0 stays clear.
- R8: Bits 13, 14 and 15 (widescreen data, closed-caption data, memory resync) are recorded, masked and cleared the same way as every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Exception event pulses, one per status bit |
| wss_cap_en_i | input | 1 | Widescreen capture mode enabled; qualifies the no-copy event |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | New mask value (1 = masked) |
| stat_rd_i | input | 1 | Status word read strobe; clears the status word |
| stat_o | output | 16 | Sticky status word |
| irq_no | output | 1 | Host interrupt, active low |

## Verification
The bench sweeps every pairing of an event bit with a single unmasked bit.
- A design that ignored the mask, or checked the wrong bit, would pull the pin low in the wrong cases.
- For a read coincident with a new event, a plain clear-on-read would drop the event.
- For a no-copy pulse with capture disabled, a missing qualifier would set bit 0.
- The bench also checks that masked events still latch, and that the reset mask keeps the pin high. A design that gated the status word with the mask, or reset the mask to zero, would fail these checks.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned EVT_W      = 16;
  localparam int unsigned NOCOPY_IDX = 0;
  localparam int unsigned WSS_IDX    = 13;
  localparam int unsigned CC_IDX     = 14;
  localparam int unsigned RESYNC_IDX = 15;
endpackage

// File: rtl/exc_evt_qual.sv
module exc_evt_qual #(
  parameter int unsigned W        = 16,
  parameter int unsigned GATE_IDX = 0
) (
  input  logic [W-1:0] evt_i,
  input  logic         gate_en_i,
  output logic [W-1:0] evt_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == GATE_IDX) begin : g_gated
      assign evt_o[g] = evt_i[g] & gate_en_i;
    end else begin : g_pass
      assign evt_o[g] = evt_i[g];
    end
  end
endmodule

// File: rtl/exc_stat_reg.sv
module exc_stat_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    // set wins over clear so a coincident event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i)    q <= 1'b0;
    end
    assign stat_o[g] = q;
  end
endmodule

// File: rtl/exc_mask_reg.sv
module exc_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  localparam logic [W-1:0] RST_VAL = '1;
  logic [W-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= RST_VAL;
    else if (we_i) mask_q <= wdata_i;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/exc_irq_gen.sv
module exc_irq_gen #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_no
);
  logic [W-1:0] live;
  assign live   = stat_i & ~mask_i;
  assign irq_no = ~(|live);
endmodule

// File: rtl/exc_irq_ctrl.sv
module exc_irq_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned W        = EVT_W,
  parameter int unsigned GATE_IDX = NOCOPY_IDX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         wss_cap_en_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] stat_o,
  output logic         irq_no
);
  logic [W-1:0] evt_q;
  logic [W-1:0] mask_q;

  exc_evt_qual #(.W(W), .GATE_IDX(GATE_IDX)) u_qual (
    .evt_i(evt_i), .gate_en_i(wss_cap_en_i), .evt_o(evt_q)
  );

  exc_stat_reg #(.W(W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_q), .clr_i(stat_rd_i), .stat_o(stat_o)
  );

  exc_mask_reg #(.W(W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_o(mask_q)
  );

  exc_irq_gen #(.W(W)) u_irq (
    .stat_i(stat_o), .mask_i(mask_q), .irq_no(irq_no)
  );
endmodule

// File: rtl/exc_irq_ctrl_chk.sv
module exc_irq_ctrl_chk #(
  parameter int unsigned W        = 16,
  parameter int unsigned GATE_IDX = 0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] evt_i,
  input logic         wss_cap_en_i,
  input logic         mask_we_i,
  input logic [W-1:0] mask_wdata_i,
  input logic         stat_rd_i,
  input logic [W-1:0] stat_o,
  input logic [W-1:0] mask_q,
  input logic         irq_no
);
  logic [W-1:0] ev_ok;
  always_comb begin
    ev_ok = evt_i;
    ev_ok[GATE_IDX] = evt_i[GATE_IDX] & wss_cap_en_i;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) !rst_ni |-> (stat_o == '0 && irq_no));

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R3
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> ((stat_o & ~$past(ev_ok)) == '0));

  // R4
  keep_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> ((stat_o & $past(ev_ok)) == $past(ev_ok)));

  // R5
  pin_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == ((stat_o & ~mask_q) == '0));

  // R6
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));

  // R7
  nocopy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wss_cap_en_i && (stat_rd_i || !stat_o[GATE_IDX])) |=> !stat_o[GATE_IDX]);
endmodule

bind exc_irq_ctrl exc_irq_ctrl_chk #(.W(W), .GATE_IDX(GATE_IDX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wss_cap_en_i(wss_cap_en_i),
  .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .stat_rd_i(stat_rd_i),
  .stat_o(stat_o), .mask_q(mask_q), .irq_no(irq_no)
);

// File: tb/sim_exc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_exc_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic        wss_cap_en_i = 1'b1;
  logic        mask_we_i = 1'b0;
  logic [15:0] mask_wdata_i = '0;
  logic        stat_rd_i = 1'b0;
  logic [15:0] stat_o;
  logic        irq_no;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] exp_stat = '0;
  logic [15:0] exp_mask = '1;

  always #2.5 clk_i = ~clk_i;

  exc_irq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wss_cap_en_i(wss_cap_en_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .stat_rd_i(stat_rd_i),
    .stat_o(stat_o), .irq_no(irq_no)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, edge captures, sample at next negedge
  task automatic cyc(input logic [15:0] ev, input logic rd, input logic we, input logic [15:0] wd);
    logic [15:0] q;
    evt_i = ev; stat_rd_i = rd; mask_we_i = we; mask_wdata_i = wd;
    q = ev;
    if (!wss_cap_en_i) q[0] = 1'b0;
    exp_stat = (rd ? 16'h0 : exp_stat) | q;
    if (we) exp_mask = wd;
    @(negedge clk_i);
    evt_i = '0; stat_rd_i = 1'b0; mask_we_i = 1'b0;
  endtask

  function automatic logic exp_irq();
    return ((exp_stat & ~exp_mask) == 16'h0);
  endfunction

  task automatic check_all(input string req);
    check(req, stat_o, exp_stat);
    check(req, {15'h0, irq_no}, {15'h0, exp_irq()});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    check("R1 stat", stat_o, 16'h0);
    check("R1 irq", {15'h0, irq_no}, 16'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset mask all ones: every event latched, pin stays high
    cyc(16'hffff, 1'b0, 1'b0, 16'h0);
    check("R1 mask reset stat", stat_o, 16'hffff);
    check("R1 mask reset irq", {15'h0, irq_no}, 16'h1);
    cyc(16'h0, 1'b1, 1'b0, 16'h0);
    check_all("R3 clear all");

    // R2 R5 R6 R8: every event bit against every single unmasked bit
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        cyc(16'h1 << i, 1'b0, 1'b0, 16'h0);
        check_all("R2 latch masked");
        cyc(16'h0, 1'b0, 1'b1, ~(16'h1 << j));
        check_all((i == j) ? "R5 R6 unmasked hit" : "R5 R6 other bit");
        if (i >= 13) check("R8 fixed bits", stat_o, 16'h1 << i);
        cyc(16'h0, 1'b0, 1'b1, 16'hffff);
        check_all("R6 remask");
        cyc(16'h0, 1'b1, 1'b0, 16'h0);
        check_all("R3 read clears");
      end
    end

    // R4: coincident event and read
    cyc(16'h00f0, 1'b0, 1'b1, 16'h0);
    check_all("R5 pending low");
    cyc(16'h0008, 1'b1, 1'b0, 16'h0);
    check("R4 keep", stat_o, 16'h0008);
    check_all("R4 pin");
    cyc(16'h0, 1'b1, 1'b0, 16'h0);
    check("R3 pin released", {15'h0, irq_no}, 16'h1);

    // R7: no-copy gating
    wss_cap_en_i = 1'b0;
    cyc(16'h0001, 1'b0, 1'b0, 16'h0);
    check("R7 gated", stat_o, 16'h0);
    check("R7 gated irq", {15'h0, irq_no}, 16'h1);
    cyc(16'h8001, 1'b0, 1'b0, 16'h0);
    check("R7 others pass", stat_o, 16'h8000);
    wss_cap_en_i = 1'b1;
    cyc(16'h0001, 1'b0, 1'b0, 16'h0);
    check("R7 enabled", stat_o, 16'h8001);
    check_all("R7 pin");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule